// File: doc/BRIEF.md
# Emulated Internal Shared-Bus Resolver

This block stands in for a shared on-chip bus that would otherwise be built from tri-state buffers. Any number of sources, each with a data word and its own output-enable bit, connect to the block. The block combines them through gating and OR logic into one resolved word. No high-impedance value appears anywhere in the logic. The result is defined for every enable pattern.

When exactly one source is enabled, its word appears on the output. When two or more sources are enabled at once, the bus resolves to all-zeros. When no source is enabled, the bus resolves to all-ones. Two status outputs report the contention case and the float case. The block has no state at all, so the output follows the inputs combinationally. The source count and the word width are parameters. The source count must be at least two.

Top module: `busResolver`

## Requirements
- R1: When exactly one bit of `drvEn` is 1, `busOut` equals the word of that source. Source k occupies bits `drvData[k*W +: W]`.
- R2: When two or more bits of `drvEn` are 1, `busOut` is all-zeros, whatever the data words hold.
- R3: When `drvEn` is all-zeros, `busOut` is all-ones, whatever the data words hold.
- R4: `contention` is 1 exactly when two or more bits of `drvEn` are 1.
- R5: `floating` is 1 exactly when no bit of `drvEn` is 1.
- R6: `contention` and `floating` are never 1 together. Both are 0 when exactly one source is enabled.
- R7: When exactly one source is enabled, the words of the disabled sources have no effect on `busOut`.
- R8: The block is purely combinational. Known inputs always give a known `busOut`, and any change on the inputs reaches the outputs without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drvData | input | N*W | Words of all sources, source k at bits k*W +: W |
| drvEn | input | N | Output-enable of each source, active high |
| busOut | output | W | Resolved bus word |
| contention | output | 1 | Two or more enables active |
| floating | output | 1 | No enable active |

## Verification
The checker re-evaluates the resolution rule whenever an input changes. It covers the pass-through word in the single-enable case, the forced values for contention and float, and the agreement of both flags with the population count of the enables. Other properties need chosen stimulus and can only come from the bench's scenarios. These are that the disabled sources' words cannot leak, that the forced values hold against hostile data such as all-ones during contention, and that every enable pattern for the default size gets exercised.

// File: rtl/busResolverPkg.sv
package busResolverPkg;

  // Strobes from the enable decoder to the word path.
  typedef struct packed {
    logic forceLow;   // several sources enabled
    logic forceHigh;  // no source enabled
  } resolveStrobe_t;

endpackage

// File: rtl/busResolverCtrl.sv
module busResolverCtrl
  import busResolverPkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   drvEn,
  output logic [N-1:0]   grant,
  output resolveStrobe_t strobe
);

  // seenChain[i]: some enable below position i is active
  logic [N:0]   seenChain;
  logic [N-1:0] clashAt;

  assign seenChain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_scan
      assign clashAt[gi]     = drvEn[gi] & seenChain[gi];
      assign seenChain[gi+1] = seenChain[gi] | drvEn[gi];
    end
  endgenerate

  logic anyClash;
  assign anyClash = |clashAt;

  always_comb begin
    strobe.forceLow  = anyClash;
    strobe.forceHigh = ~seenChain[N];
    grant            = anyClash ? '0 : drvEn;
  end

endmodule

// File: rtl/busResolverPath.sv
module busResolverPath
  import busResolverPkg::*;
#(
  parameter int N = 4,
  parameter int W = 8,
  localparam int BUS_BITS = N * W
) (
  input  logic [BUS_BITS-1:0] drvData,
  input  logic [N-1:0]        grant,
  input  resolveStrobe_t      strobe,
  output logic [W-1:0]        busOut
);

  logic [W-1:0] orChain [N+1];

  assign orChain[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_gate
      assign orChain[gi+1] = orChain[gi] | (drvData[gi*W +: W] & {W{grant[gi]}});
    end
  endgenerate

  always_comb begin
    if (strobe.forceHigh)     busOut = '1;
    else if (strobe.forceLow) busOut = '0;
    else                      busOut = orChain[N];
  end

endmodule

// File: rtl/busResolver.sv
module busResolver
  import busResolverPkg::*;
#(
  parameter int N = 4,
  parameter int W = 8,
  localparam int BUS_BITS = N * W
) (
  input  logic [BUS_BITS-1:0] drvData,
  input  logic [N-1:0]        drvEn,
  output logic [W-1:0]        busOut,
  output logic                contention,
  output logic                floating
);

  resolveStrobe_t strobe;
  logic [N-1:0]   grant;

  busResolverCtrl #(.N(N)) u_ctrl (
    .drvEn  (drvEn),
    .grant  (grant),
    .strobe (strobe)
  );

  busResolverPath #(.N(N), .W(W)) u_path (
    .drvData (drvData),
    .grant   (grant),
    .strobe  (strobe),
    .busOut  (busOut)
  );

  assign contention = strobe.forceLow;
  assign floating   = strobe.forceHigh;

endmodule

// File: rtl/busResolverChk.sv
module busResolverChk #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int BUS_BITS = N * W
) (
  input logic [BUS_BITS-1:0] drvData,
  input logic [N-1:0]        drvEn,
  input logic [W-1:0]        busOut,
  input logic                contention,
  input logic                floating
);

  logic [W-1:0] soloWord;

  always_comb begin
    soloWord = '0;
    for (int k = 0; k < N; k++)
      if (drvEn[k]) soloWord = drvData[k*W +: W];

    // R1
    single_pass_chk: assert (!($countones(drvEn) == 1) || busOut == soloWord);
    // R2
    clash_low_chk: assert (!($countones(drvEn) > 1) || busOut == '0);
    // R3
    idle_high_chk: assert (drvEn != '0 || busOut == '1);
    // R4
    clash_flag_chk: assert (contention == ($countones(drvEn) > 1));
    // R5
    idle_flag_chk: assert (floating == (drvEn == '0));
    // R6
    flag_excl_chk: assert (!(contention && floating));
  end

endmodule

bind busResolver busResolverChk #(.N(N), .W(W)) u_chk (.*);

// File: tb/busResolver_tb.sv
module busResolver_tb;

  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N*W-1:0] drvData;
  logic [N-1:0]   drvEn;
  logic [W-1:0]   busOut;
  logic           contention;
  logic           floating;

  int checks = 0;
  int errors = 0;

  busResolver #(.N(N), .W(W)) u_dut (
    .drvData    (drvData),
    .drvEn      (drvEn),
    .busOut     (busOut),
    .contention (contention),
    .floating   (floating)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [N*W-1:0] d, input logic [N-1:0] e);
    @(negedge clk);
    drvData = d;
    drvEn   = e;
    #1;
  endtask

  task automatic t_initial();
    // R3 R5: idle state at start
    apply({N{8'h5a}}, '0);
    check("R3 idle bus", busOut, '1);
    check("R5 float flag", {7'd0, floating}, 8'd1);
    check("R4 clash flag", {7'd0, contention}, 8'd0);
  endtask

  task automatic t_single();
    logic [N*W-1:0] d;
    d = 32'hc3_81_7e_00;
    for (int k = 0; k < N; k++) begin
      apply(d, N'(1) << k);
      check("R1 pass word", busOut, d[k*W +: W]);
      check("R6 flags off", {6'd0, contention, floating}, 8'd0);
    end
    apply('1, 4'b0100);
    check("R1 all-ones word", busOut, 8'hff);
    apply('0, 4'b0001);
    check("R8 zero word known", busOut, 8'h00);
  endtask

  task automatic t_ignore();
    apply(32'h00_00_3c_00, 4'b0010);
    check("R7 base", busOut, 8'h3c);
    apply(32'hff_ff_3c_ff, 4'b0010);
    check("R7 others high", busOut, 8'h3c);
    apply(32'ha5_5a_3c_96, 4'b0010);
    check("R7 others mixed", busOut, 8'h3c);
  endtask

  task automatic t_clash();
    apply('1, 4'b0011);
    check("R2 pair all-ones data", busOut, 8'h00);
    check("R4 clash flag", {7'd0, contention}, 8'd1);
    apply(32'h12_34_56_78, 4'b1111);
    check("R2 all enabled", busOut, 8'h00);
    apply(32'hff_00_ff_00, 4'b1001);
    check("R2 ends", busOut, 8'h00);
    check("R6 excl", {7'd0, floating}, 8'd0);
  endtask

  task automatic t_float();
    apply('0, '0);
    check("R3 zero data", busOut, 8'hff);
    apply(32'h01_02_03_04, '0);
    check("R3 mixed data", busOut, 8'hff);
  endtask

  task automatic t_sweep();
    logic [N*W-1:0] d;
    d = 32'h9e_47_b1_2d;
    for (int p = 0; p < (1 << N); p++) begin
      int cnt;
      logic [W-1:0] exp;
      cnt = 0;
      exp = '0;
      for (int k = 0; k < N; k++)
        if (p[k]) begin cnt++; exp = d[k*W +: W]; end
      if (cnt == 0) exp = '1;
      else if (cnt > 1) exp = '0;
      apply(d, N'(p));
      check("R1 R2 R3 sweep", busOut, exp);
      check("R4 sweep", {7'd0, contention}, {7'd0, cnt > 1});
      check("R5 sweep", {7'd0, floating}, {7'd0, cnt == 0});
    end
  endtask

  initial begin
    drvData = '0;
    drvEn   = '0;
    t_initial();
    t_single();
    t_ignore();
    t_clash();
    t_float();
    t_sweep();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule